// File: doc/BRIEF.md
# Cascaded Interrupt Priority Aggregator

This block collects 96 level-sensitive interrupt sources arranged as three banks of 32 and reduces them to a single request line toward the processor. It also reports which source has won arbitration. Each bank has an enable register, and a source takes part in arbitration only while both its status input and its enable bit are high. Two secondary groups of 32 lines hang off cascade bits. The software group is reached through a bit in bank 0, and the GPIO group is reached through a bit in bank 1. When a cascade bit is pending and its group holds a pending line, the search descends into that group and the group's lowest line wins ahead of every other source in that bank. When the group is empty, the cascade bit is simply removed from the bank's own search.

A small register port lets software program the three enable registers and the software-group enable. It also lets software raise and lower software-group status bits with separate set and clear writes. Reads are combinational from the address. A second, processor-level resolver ranks three external request lines together with the aggregated request, and it flags a spurious entry when none of them is active. The GPIO status and mask vectors arrive already qualified from neighbouring logic. Input synchronisation is outside this block.

Top module: `irq_cascade_agg`

## Requirements
- R1: Primary source n is bit n%32 of bank n/32 on `src_status_i`. A primary winner reports that bank on `win_bank_o` and that bit on `win_idx_o`.
- R2: A primary source is pending only when both its status bit and its enable bit are 1. With all enables at 0, all-ones status produces no winner.
- R3: After reset, the three bank enable registers, the software enable register and the software status register all read 0.
- R4: Within a bank, the pending bit with the lowest number wins. Any pending source in bank 0 beats all of bank 1, and any pending source in bank 1 beats all of bank 2.
- R5: Bank 0 bit `SW_CASC_BIT` (default 7) is the software cascade. If it is pending and software status AND software enable is non-zero, the lowest such software bit wins with group code 1 and bank 0. This happens ahead of every other bank-0 source.
- R6: A cascade bit is never reported as a primary winner. When its group has nothing pending, the search continues with the cascade bit masked out. If nothing else is pending, there is no winner.
- R7: Bank 1 bit `GPIO_CASC_BIT` (default 13, source 45) is the GPIO cascade. If it is pending and `gpio_status_i & gpio_mask_i` is non-zero, the lowest such bit wins with group code 2 and bank 1. This happens ahead of every other bank-1 source.
- R8: `cpu_ext_i[2]` is processor line 7, `cpu_ext_i[1]` is line 1 and `cpu_ext_i[0]` is line 0. The aggregated request is line 2. `cpu_line_o` gives the highest active line in the order 7, 2, 1, 0. When none is active, `cpu_spurious_o` is 1 and `cpu_line_o` is 0.
- R9: `win_grp_o` encodes 0 for primary, 1 for software, 2 for GPIO and 3 for no winner. With no winner, `win_bank_o` and `win_idx_o` are 0.
- R10: A write to address 4 ORs the write data into the software status register. A write to address 5 clears each status bit whose write-data bit is 1. Reading address 4 or 5 returns the software status.
- R11: `irq_o` is high exactly while a winner exists. It stays high as long as a level source remains pending and enabled.
- R12: Addresses 0, 1 and 2 write and read the enables of banks 0, 1 and 2. Address 3 writes and reads the software enable. Each write takes effect at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_status_i | input | 96 | Level status of primary sources, bank b in bits 32b+31..32b |
| gpio_status_i | input | 32 | GPIO group status |
| gpio_mask_i | input | 32 | GPIO group mask (1 = enabled) |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i` |
| cpu_ext_i | input | 3 | External processor lines 7, 1, 0 |
| irq_o | output | 1 | Aggregated interrupt request |
| win_grp_o | output | 2 | Winner group code |
| win_bank_o | output | 2 | Winner bank |
| win_idx_o | output | 5 | Winner bit index within its bank or group |
| cpu_line_o | output | 3 | Highest-priority active processor line |
| cpu_spurious_o | output | 1 | No processor line active |

## Verification
A corrupted enable bit or software status bit shows up at the winner outputs in the same cycle that a matching status input is presented. A missing bit leaves the source silent, and a stuck bit lets a disabled source win. Because the bench compares against its model on every clock under random status patterns, such a fault appears within a few cycles of the first stimulus that touches it. Faults in the priority logic appear at once as the wrong index or bank whenever two sources compete, and faults in cascade masking show up as a cascade bit reported as a winner. Register faults are also visible directly through readback on the register port.

// File: rtl/irq_agg_pkg.sv
`timescale 1ns/1ps
package irq_agg_pkg;

    localparam int unsigned BANK_W     = 32;
    localparam int unsigned IDX_W      = $clog2(BANK_W);
    localparam int unsigned NUM_BANKS  = 3;
    localparam int unsigned BANK_SEL_W = 2;
    localparam int unsigned SRC_W      = NUM_BANKS * BANK_W;
    localparam int unsigned ADDR_W     = 3;
    localparam int unsigned EXT_W      = 3;
    localparam int unsigned LINE_W     = 3;

    // register address map, derived from the bank count
    localparam logic [ADDR_W-1:0] A_SWEN  = ADDR_W'(NUM_BANKS);
    localparam logic [ADDR_W-1:0] A_SWSET = ADDR_W'(NUM_BANKS + 1);
    localparam logic [ADDR_W-1:0] A_SWCLR = ADDR_W'(NUM_BANKS + 2);

    typedef enum logic [1:0] {
        GRP_PRIM = 2'd0,
        GRP_SOFT = 2'd1,
        GRP_GPIO = 2'd2,
        GRP_NONE = 2'd3
    } grp_e;

    typedef struct packed {
        logic             hit;
        logic [IDX_W-1:0] idx;
    } pick_t;

    typedef struct packed {
        grp_e                  grp;
        logic [BANK_SEL_W-1:0] bank;
        logic [IDX_W-1:0]      idx;
    } winner_t;

    // lowest set bit of a bank-wide vector
    function automatic pick_t lowest_set(input logic [BANK_W-1:0] v);
        pick_t r;
        r.hit = |v;
        r.idx = '0;
        for (int i = BANK_W - 1; i >= 0; i--) begin
            if (v[i]) r.idx = IDX_W'(i);
        end
        return r;
    endfunction

    // which secondary group hangs off a given bank
    function automatic grp_e sec_group(input int unsigned bank);
        return (bank == 0) ? GRP_SOFT : GRP_GPIO;
    endfunction

endpackage

// File: rtl/irq_agg_regs.sv
`timescale 1ns/1ps
module irq_agg_regs
    import irq_agg_pkg::*;
(
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             wr_i,
    input  logic [ADDR_W-1:0]                addr_i,
    input  logic [BANK_W-1:0]                wdata_i,
    output logic [NUM_BANKS-1:0][BANK_W-1:0] en_o,
    output logic [BANK_W-1:0]                swen_o,
    output logic [BANK_W-1:0]                swst_o,
    output logic [BANK_W-1:0]                rdata_o
);

    logic [NUM_BANKS-1:0][BANK_W-1:0] en_q;
    logic [BANK_W-1:0]                swen_q;
    logic [BANK_W-1:0]                swst_q;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_en
        always_ff @(posedge clk) begin
            if (rst) begin
                en_q[b] <= '0;
            end else if (wr_i && addr_i == ADDR_W'(b)) begin
                en_q[b] <= wdata_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            swen_q <= '0;
        end else if (wr_i && addr_i == A_SWEN) begin
            swen_q <= wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            swst_q <= '0;
        end else if (wr_i && addr_i == A_SWSET) begin
            swst_q <= swst_q | wdata_i;
        end else if (wr_i && addr_i == A_SWCLR) begin
            swst_q <= swst_q & ~wdata_i;
        end
    end

    always_comb begin
        rdata_o = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (addr_i == ADDR_W'(b)) rdata_o = en_q[b];
        end
        if (addr_i == A_SWEN) rdata_o = swen_q;
        if (addr_i == A_SWSET || addr_i == A_SWCLR) rdata_o = swst_q;
    end

    assign en_o   = en_q;
    assign swen_o = swen_q;
    assign swst_o = swst_q;

endmodule

// File: rtl/irq_bank_pick.sv
`timescale 1ns/1ps
module irq_bank_pick
    import irq_agg_pkg::*;
#(
    parameter bit          CASC_EN  = 1'b0,
    parameter int unsigned CASC_BIT = 0
) (
    input  logic [BANK_W-1:0] status_i,
    input  logic [BANK_W-1:0] enable_i,
    input  logic [BANK_W-1:0] sec_pend_i,
    output pick_t             prim_o,
    output pick_t             sec_o
);

    localparam logic [BANK_W-1:0] CASC_MASK =
        CASC_EN ? (BANK_W'(1) << CASC_BIT) : '0;

    logic [BANK_W-1:0] pend;
    logic              casc_live;
    pick_t             sec_pick;

    always_comb begin
        pend      = status_i & enable_i;
        casc_live = |(pend & CASC_MASK);
        sec_pick  = lowest_set(sec_pend_i);
        sec_o.hit = casc_live & sec_pick.hit;
        sec_o.idx = sec_pick.idx;
        // the cascade bit never competes as a source of its own
        prim_o    = lowest_set(pend & ~CASC_MASK);
    end

endmodule

// File: rtl/irq_agg_resolve.sv
`timescale 1ns/1ps
module irq_agg_resolve
    import irq_agg_pkg::*;
(
    input  pick_t [NUM_BANKS-1:0] prim_i,
    input  pick_t [NUM_BANKS-1:0] sec_i,
    output winner_t               win_o
);

    always_comb begin
        win_o.grp  = GRP_NONE;
        win_o.bank = '0;
        win_o.idx  = '0;
        // walk from the weakest bank up so stronger entries overwrite
        for (int b = NUM_BANKS - 1; b >= 0; b--) begin
            if (prim_i[b].hit) begin
                win_o.grp  = GRP_PRIM;
                win_o.bank = BANK_SEL_W'(b);
                win_o.idx  = prim_i[b].idx;
            end
            if (sec_i[b].hit) begin
                win_o.grp  = sec_group(b);
                win_o.bank = BANK_SEL_W'(b);
                win_o.idx  = sec_i[b].idx;
            end
        end
    end

endmodule

// File: rtl/cpu_line_pri.sv
`timescale 1ns/1ps
module cpu_line_pri
    import irq_agg_pkg::*;
(
    input  logic [EXT_W-1:0]  ext_i,
    input  logic              ctrl_i,
    output logic [LINE_W-1:0] line_o,
    output logic              spurious_o
);

    always_comb begin
        spurious_o = 1'b0;
        if (ext_i[2])      line_o = LINE_W'(7);
        else if (ctrl_i)   line_o = LINE_W'(2);
        else if (ext_i[1]) line_o = LINE_W'(1);
        else if (ext_i[0]) line_o = LINE_W'(0);
        else begin
            line_o     = '0;
            spurious_o = 1'b1;
        end
    end

endmodule

// File: rtl/irq_cascade_agg.sv
`timescale 1ns/1ps
module irq_cascade_agg
    import irq_agg_pkg::*;
#(
    parameter int unsigned SW_CASC_BIT   = 7,
    parameter int unsigned GPIO_CASC_BIT = 13
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [SRC_W-1:0]      src_status_i,
    input  logic [BANK_W-1:0]     gpio_status_i,
    input  logic [BANK_W-1:0]     gpio_mask_i,
    input  logic                  reg_wr_i,
    input  logic [ADDR_W-1:0]     reg_addr_i,
    input  logic [BANK_W-1:0]     reg_wdata_i,
    output logic [BANK_W-1:0]     reg_rdata_o,
    input  logic [EXT_W-1:0]      cpu_ext_i,
    output logic                  irq_o,
    output logic [1:0]            win_grp_o,
    output logic [BANK_SEL_W-1:0] win_bank_o,
    output logic [IDX_W-1:0]      win_idx_o,
    output logic [LINE_W-1:0]     cpu_line_o,
    output logic                  cpu_spurious_o
);

    logic [NUM_BANKS-1:0][BANK_W-1:0] en_q;
    logic [BANK_W-1:0]                sw_en;
    logic [BANK_W-1:0]                sw_st;
    pick_t [NUM_BANKS-1:0]            prim;
    pick_t [NUM_BANKS-1:0]            sec;
    winner_t                          win;
    logic [NUM_BANKS-1:0]             any_prim;
    logic [NUM_BANKS-1:0]             any_sec;

    irq_agg_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_i    (reg_wr_i),
        .addr_i  (reg_addr_i),
        .wdata_i (reg_wdata_i),
        .en_o    (en_q),
        .swen_o  (sw_en),
        .swst_o  (sw_st),
        .rdata_o (reg_rdata_o)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam bit          HAS_CASC = (b < 2);
        localparam int unsigned CBIT     = (b == 0) ? SW_CASC_BIT : GPIO_CASC_BIT;
        logic [BANK_W-1:0] sec_pend;

        if (b == 0) begin : g_sw
            assign sec_pend = sw_st & sw_en;
        end else if (b == 1) begin : g_gpio
            assign sec_pend = gpio_status_i & gpio_mask_i;
        end else begin : g_flat
            assign sec_pend = '0;
        end

        irq_bank_pick #(
            .CASC_EN  (HAS_CASC),
            .CASC_BIT (CBIT)
        ) u_pick (
            .status_i   (src_status_i[b*BANK_W +: BANK_W]),
            .enable_i   (en_q[b]),
            .sec_pend_i (sec_pend),
            .prim_o     (prim[b]),
            .sec_o      (sec[b])
        );

        assign any_prim[b] = prim[b].hit;
        assign any_sec[b]  = sec[b].hit;
    end

    irq_agg_resolve u_resolve (
        .prim_i (prim),
        .sec_i  (sec),
        .win_o  (win)
    );

    assign irq_o      = |{any_prim, any_sec};
    assign win_grp_o  = win.grp;
    assign win_bank_o = win.bank;
    assign win_idx_o  = win.idx;

    cpu_line_pri u_cpu (
        .ext_i      (cpu_ext_i),
        .ctrl_i     (irq_o),
        .line_o     (cpu_line_o),
        .spurious_o (cpu_spurious_o)
    );

endmodule

// File: rtl/irq_agg_chk.sv
`timescale 1ns/1ps
module irq_agg_chk
    import irq_agg_pkg::*;
#(
    parameter int unsigned SW_CASC_BIT   = 7,
    parameter int unsigned GPIO_CASC_BIT = 13
) (
    input logic                  clk,
    input logic                  rst,
    input logic [SRC_W-1:0]      src_status,
    input logic [BANK_W-1:0]     gpio_status,
    input logic [BANK_W-1:0]     gpio_mask,
    input logic [SRC_W-1:0]      en_flat,
    input logic [BANK_W-1:0]     swen,
    input logic [BANK_W-1:0]     swst,
    input logic                  reg_wr,
    input logic [ADDR_W-1:0]     reg_addr,
    input logic [BANK_W-1:0]     reg_wdata,
    input logic [EXT_W-1:0]      cpu_ext,
    input logic                  irq,
    input logic [1:0]            grp,
    input logic [BANK_SEL_W-1:0] bank,
    input logic [IDX_W-1:0]      idx,
    input logic [LINE_W-1:0]     cpu_line,
    input logic                  cpu_spurious
);

    localparam int unsigned GPIO_SRC = BANK_W + GPIO_CASC_BIT;

    logic [BANK_W-1:0] wb_pend;
    logic [BANK_W-1:0] below_mask;
    logic [BANK_W-1:0] casc_mask;

    always_comb begin
        wb_pend    = BANK_W'((src_status & en_flat) >> (int'(bank) * BANK_W));
        below_mask = (BANK_W'(1) << idx) - BANK_W'(1);
        casc_mask  = (bank == 2'd0) ? (BANK_W'(1) << SW_CASC_BIT) :
                     (bank == 2'd1) ? (BANK_W'(1) << GPIO_CASC_BIT) : '0;
    end

    p_prim_pending_r2: assert property (@(posedge clk) disable iff (rst)
        (grp == GRP_PRIM) |-> (src_status[{bank, idx}] && en_flat[{bank, idx}]));

    p_clear_after_reset_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (en_flat == '0 && swen == '0 && swst == '0));

    p_lowest_first_r4: assert property (@(posedge clk) disable iff (rst)
        (grp == GRP_PRIM) |-> ((wb_pend & below_mask & ~casc_mask) == '0));

    p_soft_descent_r5: assert property (@(posedge clk) disable iff (rst)
        (grp == GRP_SOFT) |-> (swst[idx] && swen[idx] && bank == 2'd0 &&
                               src_status[SW_CASC_BIT] && en_flat[SW_CASC_BIT]));

    p_casc_hidden_r6: assert property (@(posedge clk) disable iff (rst)
        (grp == GRP_PRIM) |-> !((bank == 2'd0 && idx == IDX_W'(SW_CASC_BIT)) ||
                                (bank == 2'd1 && idx == IDX_W'(GPIO_CASC_BIT))));

    p_gpio_descent_r7: assert property (@(posedge clk) disable iff (rst)
        (grp == GRP_GPIO) |-> (gpio_status[idx] && gpio_mask[idx] && bank == 2'd1 &&
                               src_status[GPIO_SRC] && en_flat[GPIO_SRC]));

    p_line7_top_r8: assert property (@(posedge clk) disable iff (rst)
        cpu_ext[2] |-> (cpu_line == LINE_W'(7) && !cpu_spurious));

    p_swset_sticks_r10: assert property (@(posedge clk) disable iff (rst)
        $past(reg_wr && reg_addr == A_SWSET) |-> ((swst & $past(reg_wdata)) == $past(reg_wdata)));

    p_irq_tracks_winner_r11: assert property (@(posedge clk) disable iff (rst)
        irq == (grp != GRP_NONE));

endmodule

bind irq_cascade_agg irq_agg_chk #(
    .SW_CASC_BIT   (SW_CASC_BIT),
    .GPIO_CASC_BIT (GPIO_CASC_BIT)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .src_status   (src_status_i),
    .gpio_status  (gpio_status_i),
    .gpio_mask    (gpio_mask_i),
    .en_flat      (en_q),
    .swen         (sw_en),
    .swst         (sw_st),
    .reg_wr       (reg_wr_i),
    .reg_addr     (reg_addr_i),
    .reg_wdata    (reg_wdata_i),
    .cpu_ext      (cpu_ext_i),
    .irq          (irq_o),
    .grp          (win_grp_o),
    .bank         (win_bank_o),
    .idx          (win_idx_o),
    .cpu_line     (cpu_line_o),
    .cpu_spurious (cpu_spurious_o)
);

// File: tb/sim_irq_cascade_agg.sv
`timescale 1ns/1ps
module sim_irq_cascade_agg;

    localparam int SWC = 7;
    localparam int GPC = 13;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [95:0] src = '0;
    logic [31:0] gst = '0;
    logic [31:0] gmk = '0;
    logic        wr = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [2:0]  ext = '0;
    logic        irq;
    logic [1:0]  grp;
    logic [1:0]  bank;
    logic [4:0]  idx;
    logic [2:0]  cline;
    logic        spur;

    int total = 0;
    int bad = 0;
    bit cmp_on = 1'b0;

    logic [31:0] m_en [3];
    logic [31:0] m_swen;
    logic [31:0] m_swst;

    always #2 clk = ~clk;

    irq_cascade_agg #(.SW_CASC_BIT(SWC), .GPIO_CASC_BIT(GPC)) u0 (
        .clk(clk), .rst(rst), .src_status_i(src), .gpio_status_i(gst),
        .gpio_mask_i(gmk), .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .cpu_ext_i(ext), .irq_o(irq), .win_grp_o(grp),
        .win_bank_o(bank), .win_idx_o(idx), .cpu_line_o(cline),
        .cpu_spurious_o(spur)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // behavioural model: ordered walk over the 96 sources with group descent
    function automatic void ref_win(output int g, output int b, output int i);
        g = 3; b = 0; i = 0;
        for (int bk = 0; bk < 3; bk++) begin
            logic [31:0] p;
            logic [31:0] s;
            int cb;
            p  = src[bk*32 +: 32] & m_en[bk];
            s  = (bk == 0) ? (m_swst & m_swen) : (bk == 1) ? (gst & gmk) : 32'h0;
            cb = (bk == 0) ? SWC : GPC;
            if (bk < 2) begin
                if (p[cb] && s != 0) begin
                    for (int k = 31; k >= 0; k--) if (s[k]) i = k;
                    g = (bk == 0) ? 1 : 2;
                    b = bk;
                    return;
                end
                p[cb] = 1'b0;
            end
            if (p != 0) begin
                for (int k = 31; k >= 0; k--) if (p[k]) i = k;
                g = 0;
                b = bk;
                return;
            end
        end
    endfunction

    always @(negedge clk) begin
        if (cmp_on) begin
            int g, b, i, el;
            ref_win(g, b, i);
            el = ext[2] ? 7 : (g != 3) ? 2 : ext[1] ? 1 : ext[0] ? 0 : -1;
            chk("R4 R9", "model group", 32'(grp), 32'(g));
            chk("R1", "model bank", 32'(bank), 32'(b));
            chk("R4", "model index", 32'(idx), 32'(i));
            chk("R11", "model irq", 32'(irq), 32'(g != 3));
            chk("R8", "model cpu line", 32'(cline), (el < 0) ? 32'd0 : 32'(el));
            chk("R8", "model spurious", 32'(spur), 32'(el < 0));
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic do_write(input logic [2:0] a, input logic [31:0] d);
        step();
        wr = 1'b1; addr = a; wdata = d;
        step();
        wr = 1'b0;
        case (a)
            3'd0, 3'd1, 3'd2: m_en[a] = d;
            3'd3: m_swen = d;
            3'd4: m_swst = m_swst | d;
            3'd5: m_swst = m_swst & ~d;
            default: ;
        endcase
    endtask

    task automatic read_chk(input logic [2:0] a, input logic [31:0] exp, input string tag);
        step();
        addr = a;
        @(negedge clk);
        chk(tag, "readback", rdata, exp);
    endtask

    task automatic win_chk(input string tag, input int g, input int b, input int i);
        @(negedge clk);
        chk(tag, "group", 32'(grp), 32'(g));
        chk(tag, "bank", 32'(bank), 32'(b));
        chk(tag, "index", 32'(idx), 32'(i));
        chk(tag, "irq", 32'(irq), 32'(g != 3));
    endtask

    initial begin
        #(200000 * 4);
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int b = 0; b < 3; b++) m_en[b] = '0;
        m_swen = '0;
        m_swst = '0;
        repeat (3) step();
        rst = 1'b0;
        cmp_on = 1'b1;

        // R3 reset state, R2 no winner while all enables are clear
        src = '1;
        step();
        win_chk("R2", 3, 0, 0);
        read_chk(3'd0, 32'h0, "R3");
        read_chk(3'd1, 32'h0, "R3");
        read_chk(3'd2, 32'h0, "R3");
        read_chk(3'd3, 32'h0, "R3");
        read_chk(3'd4, 32'h0, "R3");

        // R4 lowest bit inside bank 0
        src = '0;
        do_write(3'd0, (32'h1 << 3) | (32'h1 << 10));
        src[3] = 1'b1; src[10] = 1'b1;
        step();
        win_chk("R4", 0, 0, 3);
        src[3] = 1'b0;
        step();
        win_chk("R4", 0, 0, 10);

        // R1 bank mapping for sources 40 and 70
        do_write(3'd1, 32'h1 << 8);
        do_write(3'd2, 32'h1 << 6);
        src = '0; src[40] = 1'b1;
        step();
        win_chk("R1", 0, 1, 8);
        src[40] = 1'b0; src[70] = 1'b1;
        step();
        win_chk("R1", 0, 2, 6);
        src[10] = 1'b1;
        step();
        win_chk("R4", 0, 0, 10);

        // R5 software descent, R6 empty group masking
        do_write(3'd0, (32'h1 << 3) | (32'h1 << 10) | (32'h1 << SWC));
        do_write(3'd4, (32'h1 << 5) | (32'h1 << 9));
        do_write(3'd3, 32'h1 << 9);
        src = '0; src[3] = 1'b1; src[SWC] = 1'b1;
        step();
        win_chk("R5", 1, 0, 9);
        do_write(3'd3, 32'h0);
        win_chk("R6", 0, 0, 3);
        src[3] = 1'b0;
        step();
        win_chk("R6", 3, 0, 0);

        // R10 set/clear, R12 readback
        read_chk(3'd4, 32'h220, "R10");
        do_write(3'd5, 32'h1 << 9);
        read_chk(3'd5, 32'h20, "R10");
        read_chk(3'd0, 32'h488, "R12");
        read_chk(3'd2, 32'h40, "R12");

        // R7 GPIO descent
        do_write(3'd1, (32'h1 << 8) | (32'h1 << GPC));
        src = '0; src[32 + GPC] = 1'b1;
        gst = 32'h30; gmk = 32'h10;
        step();
        win_chk("R7", 2, 1, 4);
        gmk = 32'h0;
        step();
        win_chk("R7", 3, 0, 0);
        src[40] = 1'b1;
        step();
        win_chk("R7", 0, 1, 8);

        // R8 processor line order and spurious
        src = '0; ext = 3'b011;
        step();
        @(negedge clk);
        chk("R8", "line", 32'(cline), 32'd1);
        ext = 3'b001;
        step();
        @(negedge clk);
        chk("R8", "line", 32'(cline), 32'd0);
        ext = 3'b000;
        step();
        @(negedge clk);
        chk("R8", "spurious", 32'(spur), 32'd1);
        src[40] = 1'b1; ext = 3'b110;
        step();
        @(negedge clk);
        chk("R8", "line", 32'(cline), 32'd7);
        ext = 3'b010;
        step();
        @(negedge clk);
        chk("R8", "line", 32'(cline), 32'd2);

        // random phase, checked every cycle against the model
        for (int n = 0; n < 600; n++) begin
            if (($urandom % 8) == 0) begin
                do_write(3'($urandom_range(0, 5)), $urandom & $urandom);
            end else begin
                step();
                src = {$urandom, $urandom, $urandom} & {$urandom, $urandom, $urandom}
                      & {$urandom, $urandom, $urandom};
                if (($urandom % 3) == 0) begin
                    src[SWC] = 1'b1;
                    src[32 + GPC] = 1'b1;
                end
                gst = $urandom & $urandom;
                gmk = $urandom & $urandom & $urandom;
                ext = 3'($urandom);
            end
        end

        step();
        cmp_on = 1'b0;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule